// File: doc/BRIEF.md
# Thermal Sensor Register and Alarm Logic

This block is the digital core of a temperature sensor mounted on a memory module. A digitized reading arrives on a sample input with a valid strobe. The block stores the reading and compares it against three programmable thresholds: a critical limit, an upper limit and a lower limit. It keeps one alarm flag per threshold. The critical and upper flags release only after the reading has dropped by a selectable hysteresis margin below their limits.

Software reaches eight 16-bit registers through a flat parallel port. The port has a shared address, a write strobe, write data and combinational read data. The alarm flags are read back in the top three bits of the temperature register. A registered, active-high event output reports the enabled alarms.

Two lock bits protect the limits. One freezes the critical limit and the other freezes the upper/lower window. A shutdown bit stops sample intake, and a critical-only mode hides the window alarms. The serial bus slave, the analog front end and the converter sit outside this block.

Top module: `tsense_core`

## Requirements
- R1: After reset every limit register, the configuration register and the temperature register read 0, and `event_o` is 0.
- R2: Address 0 reads `{13'b0, EXT_RANGE, 2'b0}`, address 6 reads `MANUF_ID` and address 7 reads `DEVICE_ID`. Writes to addresses 0, 5, 6 and 7 change no register.
- R3: The configuration register (address 1) keeps only these fields: bit 2 critical-only, bit 6 critical lock, bit 7 window lock, bit 8 shutdown, bits 10:9 hysteresis code. Every other bit reads 0.
- R4: A write to address 2 (upper), 3 (lower) or 4 (critical) stores `wdata[12:0]` as a 13-bit two's-complement value in steps of 0.0625 °C. The value is clamped to the range [floor, 2000]. The floor is -640 when `EXT_RANGE` is 1 and 0 otherwise. The limit reads back in bits 12:0, and bits 15:13 read 0.
- R5: One cycle after an accepted sample, address 5 bits 12:0 hold that sample.
- R6: Bit 15 of address 5 is the critical flag. It sets when a sample is greater than the critical limit and clears when a sample is less than the critical limit minus H. Otherwise it holds. H in LSBs is 0, 24, 48 or 96 for hysteresis codes 0, 1, 2 and 3.
- R7: Bit 14 of address 5 is the upper flag. It follows the rule of R6 against the upper limit with the same H.
- R8: Bit 13 of address 5 is the lower flag. It sets when a sample is less than the lower limit, clears when a sample is greater than the lower limit, and holds when they are equal.
- R9: While critical-only mode is set, bits 14:13 of address 5 read 0.
- R10: `event_o` is the OR of the critical flag and, unless critical-only mode is set, the upper and lower flags. It is registered and changes only in the cycle after an accepted sample.
- R11: While shutdown is set, samples are not accepted. The stored temperature, the flags and `event_o` hold.
- R12: While the critical lock is set, writes to address 4 are ignored. Once set, the critical lock clears only on reset.
- R13: While the window lock is set, writes to addresses 2 and 3 are ignored. Once set, the window lock clears only on reset.
- R14: A configuration write updates the hysteresis code only if both locks were clear before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 3 | Register address for read and write |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| samp_valid | input | 1 | Temperature sample strobe |
| samp_temp | input | 13 | Temperature sample, two's complement, 0.0625 °C LSB |
| event_o | output | 1 | Alarm event, active high |

## Verification
The bench builds the block with `EXT_RANGE` = 1 and with ID values that differ from each other. This makes the -40 °C clamp floor reachable and keeps the ID readback distinct from the other registers. With these values, a write sweep over all 8192 codes of a limit field covers both clamp edges and the sign boundary. Sample ramps rise and fall in steps of 4 LSB from below zero to past the critical limit under each of the four hysteresis codes, so every set, hold and clear threshold is crossed in both directions.

// File: rtl/tsense_pkg.sv
package tsense_pkg;
  localparam int TW    = 13;
  localparam int RW    = 16;
  localparam int AW    = 3;
  localparam int XW    = TW + 2;
  localparam int HYST_UNIT = 12;

  localparam logic [AW-1:0] AD_CAP   = 3'd0;
  localparam logic [AW-1:0] AD_CFG   = 3'd1;
  localparam logic [AW-1:0] AD_UPPER = 3'd2;
  localparam logic [AW-1:0] AD_LOWER = 3'd3;
  localparam logic [AW-1:0] AD_CRIT  = 3'd4;
  localparam logic [AW-1:0] AD_TEMP  = 3'd5;
  localparam logic [AW-1:0] AD_MFG   = 3'd6;
  localparam logic [AW-1:0] AD_DEV   = 3'd7;

  localparam int CB_CRIT_ONLY = 2;
  localparam int CB_LOCK_CRIT = 6;
  localparam int CB_LOCK_WIN  = 7;
  localparam int CB_SHDN      = 8;
  localparam int CB_HYST      = 9;
  localparam int CAPB_EXT     = 2;

  typedef struct packed {
    logic [1:0] hyst;
    logic       shdn;
    logic       lock_win;
    logic       lock_crit;
    logic       crit_only;
  } cfg_t;

  function automatic logic signed [XW-1:0] widen(input logic [TW-1:0] v);
    return {{(XW-TW){v[TW-1]}}, v};
  endfunction

  function automatic logic [TW-1:0] clamp_limit(input logic [TW-1:0] raw,
                                                input int lo, input int hi);
    logic signed [XW-1:0] v;
    v = widen(raw);
    if (v < XW'(lo)) v = XW'(lo);
    else if (v > XW'(hi)) v = XW'(hi);
    return v[TW-1:0];
  endfunction

  function automatic logic signed [XW-1:0] hyst_lsb(input logic [1:0] code);
    if (code == 2'd0) return '0;
    return XW'(HYST_UNIT) << code;
  endfunction

  function automatic logic high_next(input logic cur, input logic [TW-1:0] s,
                                     input logic [TW-1:0] lim,
                                     input logic signed [XW-1:0] h);
    logic signed [XW-1:0] se, le;
    se = widen(s);
    le = widen(lim);
    if (se > le) return 1'b1;
    if (se < le - h) return 1'b0;
    return cur;
  endfunction

  function automatic logic low_next(input logic cur, input logic [TW-1:0] s,
                                    input logic [TW-1:0] lim);
    logic signed [XW-1:0] se, le;
    se = widen(s);
    le = widen(lim);
    if (se < le) return 1'b1;
    if (se > le) return 1'b0;
    return cur;
  endfunction
endpackage

// File: rtl/tsense_cfg.sv
module tsense_cfg
  import tsense_pkg::*;
#(
  parameter bit EXT_RANGE = 1'b0,
  parameter int LIM_MAX   = 2000,
  parameter int EXT_MIN   = -640
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [RW-1:0] wdata,
  output cfg_t          cfg,
  output logic [TW-1:0] upper,
  output logic [TW-1:0] lower,
  output logic [TW-1:0] crit
);
  localparam int LIM_MIN = EXT_RANGE ? EXT_MIN : 0;

  logic wr_cfg, wr_upper_ok, wr_lower_ok, wr_crit_ok, hyst_open;
  logic [TW-1:0] lim_in;
  logic wdata_unused;

  assign wr_cfg      = wr && (addr == AD_CFG);
  assign hyst_open   = !cfg.lock_crit && !cfg.lock_win;
  assign wr_upper_ok = wr && (addr == AD_UPPER) && !cfg.lock_win;
  assign wr_lower_ok = wr && (addr == AD_LOWER) && !cfg.lock_win;
  assign wr_crit_ok  = wr && (addr == AD_CRIT)  && !cfg.lock_crit;
  assign lim_in      = clamp_limit(wdata[TW-1:0], LIM_MIN, LIM_MAX);
  assign wdata_unused = ^{wdata[RW-1:11], wdata[5:3], wdata[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr_cfg) begin
      cfg.crit_only <= wdata[CB_CRIT_ONLY];
      cfg.shdn      <= wdata[CB_SHDN];
      cfg.lock_crit <= cfg.lock_crit | wdata[CB_LOCK_CRIT];
      cfg.lock_win  <= cfg.lock_win  | wdata[CB_LOCK_WIN];
      if (hyst_open) cfg.hyst <= wdata[CB_HYST+1:CB_HYST];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper <= '0;
      lower <= '0;
      crit  <= '0;
    end else begin
      if (wr_upper_ok) upper <= lim_in;
      if (wr_lower_ok) lower <= lim_in;
      if (wr_crit_ok)  crit  <= lim_in;
    end
  end

  // R12
  crit_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.lock_crit |=> (cfg.lock_crit && $stable(crit)));
  // R13
  win_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.lock_win |=> (cfg.lock_win && $stable(upper) && $stable(lower)));
  // R14
  hyst_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.lock_crit || cfg.lock_win) |=> $stable(cfg.hyst));
  // R4
  limit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_upper_ok |=> (($signed(upper) <= $signed(TW'(LIM_MAX))) &&
                     ($signed(upper) >= $signed(TW'(LIM_MIN)))));
endmodule

// File: rtl/tsense_alarm.sv
module tsense_alarm
  import tsense_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          samp_valid,
  input  logic [TW-1:0] samp_temp,
  input  cfg_t          cfg,
  input  logic [TW-1:0] upper,
  input  logic [TW-1:0] lower,
  input  logic [TW-1:0] crit,
  output logic [TW-1:0] temp_q,
  output logic          flag_crit,
  output logic          flag_up,
  output logic          flag_lo,
  output logic          event_o
);
  localparam int NHI = 2;

  logic accept;
  logic signed [XW-1:0] hyst_w;
  logic [TW-1:0] hi_lim [NHI];
  logic [NHI-1:0] hi_cur, hi_nxt;
  logic lo_nxt, evt_nxt;

  assign accept    = samp_valid && !cfg.shdn;
  assign hyst_w    = hyst_lsb(cfg.hyst);
  assign hi_lim[0] = crit;
  assign hi_lim[1] = upper;
  assign hi_cur    = {flag_up, flag_crit};

  for (genvar g = 0; g < NHI; g++) begin : g_high
    assign hi_nxt[g] = high_next(hi_cur[g], samp_temp, hi_lim[g], hyst_w);
  end

  assign lo_nxt  = low_next(flag_lo, samp_temp, lower);
  assign evt_nxt = hi_nxt[0] | (!cfg.crit_only & (hi_nxt[1] | lo_nxt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      temp_q    <= '0;
      flag_crit <= 1'b0;
      flag_up   <= 1'b0;
      flag_lo   <= 1'b0;
      event_o   <= 1'b0;
    end else if (accept) begin
      temp_q    <= samp_temp;
      flag_crit <= hi_nxt[0];
      flag_up   <= hi_nxt[1];
      flag_lo   <= lo_nxt;
      event_o   <= evt_nxt;
    end
  end

  // R11
  shutdown_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.shdn |=> ($stable(temp_q) && $stable(flag_crit) && $stable(event_o)));
  // R10
  event_only_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(event_o));
  // R6
  crit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ($signed(samp_temp) > $signed(crit))) |=> (flag_crit && event_o));
  // R8
  lower_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ($signed(samp_temp) < $signed(lower))) |=> flag_lo);
  // R5
  temp_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (temp_q == $past(samp_temp)));
endmodule

// File: rtl/tsense_core.sv
module tsense_core
  import tsense_pkg::*;
#(
  parameter bit          EXT_RANGE = 1'b0,
  parameter logic [15:0] MANUF_ID  = 16'h0F3C,
  parameter logic [15:0] DEVICE_ID = 16'h0A01,
  parameter int          LIM_MAX   = 2000,
  parameter int          EXT_MIN   = -640
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        samp_valid,
  input  logic [12:0] samp_temp,
  output logic        event_o
);
  cfg_t cfg;
  logic [TW-1:0] upper, lower, crit, temp_q;
  logic flag_crit, flag_up, flag_lo;
  logic [RW-1:0] cap_word, cfg_word, temp_word;

  tsense_cfg #(
    .EXT_RANGE(EXT_RANGE), .LIM_MAX(LIM_MAX), .EXT_MIN(EXT_MIN)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .cfg(cfg), .upper(upper), .lower(lower), .crit(crit)
  );

  tsense_alarm u_alarm (
    .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp_temp(samp_temp),
    .cfg(cfg), .upper(upper), .lower(lower), .crit(crit), .temp_q(temp_q),
    .flag_crit(flag_crit), .flag_up(flag_up), .flag_lo(flag_lo), .event_o(event_o)
  );

  always_comb begin
    cap_word = '0;
    cap_word[CAPB_EXT] = EXT_RANGE;
    cfg_word = '0;
    cfg_word[CB_CRIT_ONLY]        = cfg.crit_only;
    cfg_word[CB_LOCK_CRIT]        = cfg.lock_crit;
    cfg_word[CB_LOCK_WIN]         = cfg.lock_win;
    cfg_word[CB_SHDN]             = cfg.shdn;
    cfg_word[CB_HYST+1:CB_HYST]   = cfg.hyst;
    temp_word = {flag_crit, flag_up & !cfg.crit_only, flag_lo & !cfg.crit_only, temp_q};
  end

  always_comb begin
    case (reg_addr)
      AD_CAP:   reg_rdata = cap_word;
      AD_CFG:   reg_rdata = cfg_word;
      AD_UPPER: reg_rdata = {{(RW-TW){1'b0}}, upper};
      AD_LOWER: reg_rdata = {{(RW-TW){1'b0}}, lower};
      AD_CRIT:  reg_rdata = {{(RW-TW){1'b0}}, crit};
      AD_TEMP:  reg_rdata = temp_word;
      AD_MFG:   reg_rdata = MANUF_ID;
      AD_DEV:   reg_rdata = DEVICE_ID;
      default:  reg_rdata = '0;
    endcase
  end

  // R9
  crit_only_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.crit_only && reg_addr == AD_TEMP) |-> (reg_rdata[14:13] == 2'b00));
  // R3
  cfg_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == AD_CFG) |-> ((reg_rdata & 16'hF83B) == 16'h0000));
endmodule

// File: tb/sim_tsense_core.sv
module sim_tsense_core;
  localparam logic [15:0] MID = 16'h1A2B;
  localparam logic [15:0] DID = 16'h0C05;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic samp_valid = 1'b0;
  logic [12:0] samp_temp = '0;
  logic event_o;

  int tests = 0;
  int fails = 0;

  int m_crit, m_up, m_lo, m_h;
  bit m_co, m_shdn, fc, fu, fl, m_ev;
  int m_temp;

  always #4 clk = ~clk;

  tsense_core #(.EXT_RANGE(1'b1), .MANUF_ID(MID), .DEVICE_ID(DID)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .samp_valid(samp_valid),
    .samp_temp(samp_temp), .event_o(event_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  function automatic int hyst_of(input int code);
    int tbl [4] = '{0, 24, 48, 96};
    return tbl[code];
  endfunction

  function automatic logic [15:0] temp_word();
    logic [12:0] t13;
    t13 = m_temp[12:0];
    return {fc, fu & !m_co, fl & !m_co, t13};
  endfunction

  task automatic sample(input int s, input string req);
    logic [15:0] v;
    @(negedge clk);
    samp_valid = 1'b1; samp_temp = s[12:0];
    @(negedge clk);
    samp_valid = 1'b0;
    if (!m_shdn) begin
      m_temp = s;
      if (s > m_crit) fc = 1; else if (s < m_crit - m_h) fc = 0;
      if (s > m_up) fu = 1; else if (s < m_up - m_h) fu = 0;
      if (s < m_lo) fl = 1; else if (s > m_lo) fl = 0;
      m_ev = fc | (!m_co & (fu | fl));
    end
    #1 chk({req, " R10 event"}, {15'd0, event_o}, {15'd0, m_ev});
    rd(3'd5, v);
    chk({req, " R5/R6/R7/R8 temp"}, v, temp_word());
  endtask

  function automatic logic [15:0] clamp_exp(input int raw13);
    int sv;
    logic [12:0] r;
    sv = (raw13 >= 4096) ? raw13 - 8192 : raw13;
    if (sv < -640) sv = -640;
    if (sv > 2000) sv = 2000;
    r = sv[12:0];
    return {3'b000, r};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    m_crit = 0; m_up = 0; m_lo = 0; m_h = 0; m_co = 0; m_shdn = 0;
    fc = 0; fu = 0; fl = 0; m_ev = 0; m_temp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R2 identification
    #1 chk("R1 event", {15'd0, event_o}, 16'h0000);
    rd(3'd0, v); chk("R2 cap", v, 16'h0004);
    rd(3'd1, v); chk("R1 cfg", v, 16'h0000);
    rd(3'd2, v); chk("R1 upper", v, 16'h0000);
    rd(3'd3, v); chk("R1 lower", v, 16'h0000);
    rd(3'd4, v); chk("R1 crit", v, 16'h0000);
    rd(3'd5, v); chk("R1 temp", v, 16'h0000);
    rd(3'd6, v); chk("R2 mfg", v, MID);
    rd(3'd7, v); chk("R2 dev", v, DID);

    // R3 reserved config bits
    wr(3'd1, 16'hFA04); rd(3'd1, v); chk("R3 cfg mask", v, 16'h0204);
    wr(3'd1, 16'h0000); rd(3'd1, v); chk("R3 cfg clear", v, 16'h0000);

    // R4 full sweep of the limit field, garbage in bits 15:13
    for (int i = 0; i < 8192; i++) begin
      logic [12:0] c;
      c = i[12:0];
      wr(3'd2, {3'b101, c});
      rd(3'd2, v);
      chk("R4 upper clamp", v, clamp_exp(i));
    end
    wr(3'd3, 16'h1000); rd(3'd3, v); chk("R4 lower floor", v, 16'h1D80);
    wr(3'd4, 16'h0FFF); rd(3'd4, v); chk("R4 crit ceiling", v, 16'h07D0);

    // thresholds for alarm sweeps
    wr(3'd2, 16'd640); m_up = 640;
    wr(3'd3, 16'd160); m_lo = 160;
    wr(3'd4, 16'd800); m_crit = 800;

    // R6 R7 R8 ramps under every hysteresis code
    for (int code = 0; code < 4; code++) begin
      wr(3'd1, 16'(code << 9)); m_h = hyst_of(code); m_co = 0;
      rd(3'd1, v); chk("R14 hyst writable", v, 16'(code << 9));
      for (int s = -64; s <= 880; s += 4) sample(s, "ramp up");
      for (int s = 880; s >= -64; s -= 4) sample(s, "ramp down");
    end

    // R9 critical-only ramp
    wr(3'd1, 16'h0204); m_h = 24; m_co = 1;
    for (int s = -64; s <= 880; s += 8) sample(s, "R9 up");
    for (int s = 880; s >= -64; s -= 8) sample(s, "R9 down");

    // R13 window lock, R14 hysteresis freeze
    wr(3'd1, 16'h0680); m_co = 0; m_h = 96;
    rd(3'd1, v); chk("R13 lock set", v, 16'h0680);
    wr(3'd1, 16'h0200);
    rd(3'd1, v); chk("R13/R14 lock sticky", v, 16'h0680);
    wr(3'd2, 16'd100); rd(3'd2, v); chk("R13 upper locked", v, 16'd640);
    wr(3'd3, 16'd100); rd(3'd3, v); chk("R13 lower locked", v, 16'd160);
    wr(3'd4, 16'd900); m_crit = 900;
    rd(3'd4, v); chk("R12 crit open", v, 16'd900);

    // R12 critical lock
    wr(3'd1, 16'h00C4); m_co = 1;
    rd(3'd1, v); chk("R12 both locks", v, 16'h06C4);
    wr(3'd4, 16'd500); rd(3'd4, v); chk("R12 crit locked", v, 16'd900);
    sample(950, "R9 crit only high");

    // R11 shutdown
    wr(3'd1, 16'h0104); m_shdn = 1;
    rd(3'd1, v); chk("R11 shutdown cfg", v, 16'h07C4);
    sample(0, "R11 shutdown hold");
    sample(-500, "R11 shutdown hold2");

    // R2 read-only addresses
    wr(3'd0, 16'hFFFF); wr(3'd5, 16'h1234); wr(3'd6, 16'hFFFF); wr(3'd7, 16'h0000);
    rd(3'd0, v); chk("R2 cap ro", v, 16'h0004);
    rd(3'd5, v); chk("R2 temp ro", v, temp_word());
    rd(3'd6, v); chk("R2 mfg ro", v, MID);
    rd(3'd7, v); chk("R2 dev ro", v, DID);

    // R1 R12 locks released only by reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(3'd1, v); chk("R1 R12 lock reset", v, 16'h0000);
    rd(3'd4, v); chk("R1 crit reset", v, 16'h0000);
    #1 chk("R1 event reset", {15'd0, event_o}, 16'h0000);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule